// File: doc/BRIEF.md
# Packet Batching Flush Controller

This block gathers received Ethernet frames into an on-chip word buffer so that a host sees them as one large batch written to its memory, not as a trickle of single reads. Frames arrive one word per cycle on a valid/last stream with no backpressure. Each stored frame takes one length word (its word count) followed by its data words. A frame that cannot be stored whole is discarded and counted.

A flush starts when the stored word count reaches a programmable threshold, or when a programmable cycle limit has passed since the first frame entered an empty buffer. The host sets that limit; 5 ms is 625000 cycles at 125 MHz. During a flush the block sends the batch on a memory-write request channel with valid/ready handshaking. The batch is a header word holding the frame count, then the stored words in arrival order, at word offsets 0, 1, 2 and so on. Beats are grouped into bursts of bounded length, and each burst is acknowledged by a separate pulse. A level interrupt rises only after every burst has been acknowledged. It stays high until the host pulses an acknowledge input, and no further flush starts while it is pending.

Top module: `batch_flush_ctrl`

## Requirements
- R1: The batch is written at word offsets 0, 1, 2 and so on. Offset 0 holds the number of stored frames. Then, for each frame in arrival order, one word holds the frame's data-word count and the frame's data words follow it.
- R2: A flush starts when the stored word count, length words included, is at least `thresh_i`. No flush starts while the count is below `thresh_i` and the timer has not expired.
- R3: The timer counts cycles while the buffer holds at least one frame and no flush is running. A flush starts once the timer reaches `timeout_i`. An empty buffer never starts a flush, whatever the timer setting.
- R4: A burst holds at most BURST beats, and `wr_last_o` marks its final beat. While `wr_valid_o` is high and `wr_ready_i` is low, the valid signal, address and data stay unchanged.
- R5: `irq_o` rises only after every burst of the batch has been acknowledged on `wr_ack_i`. It stays high until `irq_ack_i` is pulsed. While it is high, no write beat is issued.
- R6: A frame that starts during a flush, or is still arriving when a flush starts, is discarded, and `drop_cnt_o` increments by one.
- R7: A frame is discarded and counted when, at its first word, fewer than MAX_FRAME+1 words are free in the buffer.
- R8: A frame of more than MAX_FRAME data words is discarded and counted. A frame of exactly MAX_FRAME words is stored.
- R9: After a flush completes, the buffer is empty. The next batch starts again at offset 0 and holds only frames committed after that flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Frame word valid |
| in_data_i | input | DATA_W | Frame word |
| in_last_i | input | 1 | Final word of the frame |
| thresh_i | input | $clog2(DEPTH+1) | Flush threshold in stored words |
| timeout_i | input | TMR_W | Flush timeout in cycles |
| irq_ack_i | input | 1 | Host interrupt acknowledge pulse |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted |
| wr_addr_o | output | $clog2(DEPTH+1)+1 | Word offset within the batch |
| wr_data_o | output | DATA_W | Write beat data |
| wr_last_o | output | 1 | Final beat of the burst |
| wr_ack_i | input | 1 | Burst completion pulse, one per burst |
| irq_o | output | 1 | Batch-landed interrupt level |
| drop_cnt_o | output | DROP_W | Discarded frame count |

## Verification
The bench builds the block with DEPTH=32, MAX_FRAME=8, BURST=4 and TMR_W=12. With a 32-word buffer, three 8-word frames take 27 words and leave 5 free, so the fit check can refuse frames after only a few of them. BURST=4 makes every batch span several bursts, including a short final one, so burst boundaries and acknowledge counting are exercised. The 12-bit timer lets the timeout case run in tens of cycles, and a ready input held low keeps a flush open long enough to send frames into it.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SEND,
    SEQ_DRAIN
  } seq_state_e;
endpackage

// File: rtl/bfc_frame_store.sv
module bfc_frame_store #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 64,
  parameter int MAX_FRAME = 16,
  parameter int DROP_W    = 16,
  localparam int AW       = $clog2(DEPTH),
  localparam int PTR_W    = $clog2(DEPTH + 1),
  localparam int LEN_W    = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  input  logic              accept_i,
  input  logic              clr_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PTR_W-1:0]  used_o,
  output logic [PTR_W-1:0]  frames_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              in_frame_q, frame_ok_q;
  logic [LEN_W-1:0]  len_q;
  logic [PTR_W-1:0]  used_q, frames_q;
  logic [DROP_W-1:0] drop_q;

  logic              sof, fits, ok_word;
  logic [LEN_W-1:0]  len_cur;
  logic [PTR_W-1:0]  free_w, data_idx;

  assign sof      = in_valid_i & ~in_frame_q;
  assign free_w   = PTR_W'(DEPTH) - used_q;
  assign fits     = free_w >= PTR_W'(MAX_FRAME + 1);
  assign len_cur  = sof ? '0 : len_q;
  // word is kept only if the whole frame so far was kept and still fits
  assign ok_word  = accept_i & (sof ? fits : frame_ok_q) & (len_cur < LEN_W'(MAX_FRAME));
  assign data_idx = used_q + PTR_W'(len_cur) + PTR_W'(1);

  always_ff @(posedge clk_i) begin
    if (in_valid_i && ok_word) begin
      mem_q[data_idx[AW-1:0]] <= in_data_i;
      if (in_last_i) mem_q[used_q[AW-1:0]] <= DATA_W'(len_cur) + DATA_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      frame_ok_q <= 1'b0;
      len_q      <= '0;
      used_q     <= '0;
      frames_q   <= '0;
      drop_q     <= '0;
    end else begin
      if (in_valid_i) begin
        in_frame_q <= ~in_last_i;
        frame_ok_q <= ok_word;
        if (len_cur < LEN_W'(MAX_FRAME)) len_q <= len_cur + LEN_W'(1);
        else                              len_q <= len_cur;
        if (in_last_i) begin
          if (ok_word) begin
            used_q   <= used_q + PTR_W'(len_cur) + PTR_W'(2);
            frames_q <= frames_q + PTR_W'(1);
          end else begin
            drop_q <= drop_q + DROP_W'(1);
          end
        end
      end
      if (clr_i) begin
        used_q   <= '0;
        frames_q <= '0;
      end
    end
  end

  assign rd_data_o  = mem_q[rd_addr_i];
  assign used_o     = used_q;
  assign frames_o   = frames_q;
  assign drop_cnt_o = drop_q;

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_q <= PTR_W'(DEPTH));
  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept_i && !clr_i) |=> $stable(used_q));
endmodule

// File: rtl/bfc_flush_trigger.sv
module bfc_flush_trigger #(
  parameter int PTR_W = 7,
  parameter int TMR_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] used_i,
  input  logic             flushing_i,
  input  logic             busy_i,
  input  logic [PTR_W-1:0] thresh_i,
  input  logic [TMR_W-1:0] timeout_i,
  output logic             start_o
);
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tmr_q <= '0;
    else if (used_i == '0 || flushing_i)  tmr_q <= '0;
    else if (~&tmr_q)                     tmr_q <= tmr_q + TMR_W'(1);
  end

  assign start_o = ~busy_i & (used_i != '0) &
                   ((used_i >= thresh_i) | (tmr_q >= timeout_i));

  p_tmr_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_i == '0) |=> (tmr_q == '0));
endmodule

// File: rtl/bfc_burst_seq.sv
module bfc_burst_seq
  import bfc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BURST  = 8,
  parameter int PTR_W  = 7,
  parameter int AW     = 6,
  localparam int IDX_W = PTR_W + 1,
  localparam int BW    = $clog2(BURST)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PTR_W-1:0]  used_i,
  input  logic [PTR_W-1:0]  frames_i,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [IDX_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_last_o,
  input  logic              wr_ack_i,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic              flushing_o,
  output logic              clr_o
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q, pend_q;
  logic [BW-1:0]    beat_q;
  logic             irq_q;
  logic             last_word, fire, issue, ack_ok, done;

  assign last_word  = idx_q == IDX_W'(used_i);
  assign wr_valid_o = state_q == SEQ_SEND;
  assign wr_last_o  = wr_valid_o & ((beat_q == BW'(BURST - 1)) | last_word);
  assign fire       = wr_valid_o & wr_ready_i;
  assign issue      = fire & wr_last_o;
  assign ack_ok     = wr_ack_i & (pend_q != '0);
  assign done       = (state_q == SEQ_DRAIN) & (pend_q == '0);
  assign rd_addr_o  = AW'(idx_q - IDX_W'(1));
  assign wr_addr_o  = idx_q;
  assign wr_data_o  = (idx_q == '0) ? DATA_W'(frames_i) : rd_data_i;
  assign irq_o      = irq_q;
  assign flushing_o = state_q != SEQ_IDLE;
  assign clr_o      = done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      beat_q  <= '0;
      pend_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      pend_q <= pend_q + IDX_W'(issue) - IDX_W'(ack_ok);
      if (done)           irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_SEND;
          idx_q   <= '0;
          beat_q  <= '0;
        end
        SEQ_SEND: if (fire) begin
          idx_q  <= idx_q + IDX_W'(1);
          beat_q <= wr_last_o ? '0 : beat_q + BW'(1);
          if (last_word) state_q <= SEQ_DRAIN;
        end
        SEQ_DRAIN: if (done) state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));
  p_quiet_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !wr_valid_o);
  p_acked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (pend_q == '0));
endmodule

// File: rtl/batch_flush_ctrl.sv
module batch_flush_ctrl #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 64,
  parameter int MAX_FRAME = 16,
  parameter int BURST     = 8,
  parameter int TMR_W     = 20,
  parameter int DROP_W    = 16,
  localparam int AW       = $clog2(DEPTH),
  localparam int PTR_W    = $clog2(DEPTH + 1),
  localparam int IDX_W    = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  input  logic [PTR_W-1:0]  thresh_i,
  input  logic [TMR_W-1:0]  timeout_i,
  input  logic              irq_ack_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [IDX_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_last_o,
  input  logic              wr_ack_i,
  output logic              irq_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic              flushing, clr, start;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [PTR_W-1:0]  used, frames;

  bfc_frame_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME), .DROP_W(DROP_W)
  ) store_i (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_last_i,
    .accept_i  (~flushing),
    .clr_i     (clr),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .used_o    (used),
    .frames_o  (frames),
    .drop_cnt_o
  );

  bfc_flush_trigger #(.PTR_W(PTR_W), .TMR_W(TMR_W)) trig_i (
    .clk_i, .rst_ni,
    .used_i     (used),
    .flushing_i (flushing),
    .busy_i     (flushing | irq_o),
    .thresh_i, .timeout_i,
    .start_o    (start)
  );

  bfc_burst_seq #(
    .DATA_W(DATA_W), .BURST(BURST), .PTR_W(PTR_W), .AW(AW)
  ) seq_i (
    .clk_i, .rst_ni,
    .start_i    (start),
    .used_i     (used),
    .frames_i   (frames),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .wr_valid_o, .wr_ready_i, .wr_addr_o, .wr_data_o, .wr_last_o,
    .wr_ack_i, .irq_ack_i, .irq_o,
    .flushing_o (flushing),
    .clr_o      (clr)
  );
endmodule

// File: tb/batch_flush_ctrl_tb_top.sv
module batch_flush_ctrl_tb_top;
  localparam int DATA_W = 32, DEPTH = 32, MAX_FRAME = 8, BURST = 4, TMR_W = 12, DROP_W = 8;
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = PTR_W + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, irq_ack = 1'b0, wr_ready = 1'b0, wr_ack = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic [PTR_W-1:0]  thresh = '1;
  logic [TMR_W-1:0]  timeout = '1;
  logic              wr_valid, wr_last, irq;
  logic [IDX_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DROP_W-1:0] drop_cnt;

  always #4 clk = ~clk;

  batch_flush_ctrl #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME),
    .BURST(BURST), .TMR_W(TMR_W), .DROP_W(DROP_W)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_last_i(in_last), .thresh_i(thresh), .timeout_i(timeout), .irq_ack_i(irq_ack),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_last_o(wr_last), .wr_ack_i(wr_ack),
    .irq_o(irq), .drop_cnt_o(drop_cnt)
  );

  int n_chk = 0, n_fail = 0;
  int exp_drop = 0;
  // host model state, written only by the monitor below
  logic [DATA_W-1:0] host [64];
  int beats = 0, issued = 0, acked = 0, cur_len = 0, bad_burst = 0, early_irq = 0, irq_beat = 0;
  int cyc = 0;
  int ready_mode = 0;   // 0 always ready, 1 alternate, 2 stalled
  bit ack_hold = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      wr_ready = 1'b0;
      wr_ack   = 1'b0;
    end else begin
      wr_ack = !ack_hold && (issued > acked);
      if (wr_ack) acked = acked + 1;
      wr_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? cyc[0] : 1'b0;
      if (irq && issued != acked) early_irq = early_irq + 1;
      if (irq && wr_valid) irq_beat = irq_beat + 1;
      if (wr_valid && wr_ready) begin
        host[wr_addr[5:0]] = wr_data;
        beats  = beats + 1;
        cur_len = cur_len + 1;
        if (wr_last) begin
          if (cur_len > BURST) bad_burst = bad_burst + 1;
          cur_len = 0;
          issued = issued + 1;
        end else if (cur_len >= BURST) begin
          bad_burst = bad_burst + 1;
        end
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input logic [DATA_W-1:0] base);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = base + DATA_W'(i);
      in_last  = (i == len - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int k = 0;
    while (!irq && k < 3000) begin
      @(negedge clk);
      k++;
    end
    check(req, 64'(irq), 64'd1);
  endtask

  task automatic do_irq_ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R5 reset irq", 64'(irq), 64'd0);
    check("R4 reset valid", 64'(wr_valid), 64'd0);
    check("R6 reset drop", 64'(drop_cnt), 64'd0);
  endtask

  task automatic t_threshold();
    int b0;
    thresh = PTR_W'(12);
    timeout = '1;
    ready_mode = 1;
    b0 = beats;
    send_frame(3, 32'h100);
    send_frame(3, 32'h200);
    repeat (20) @(negedge clk);
    check("R2 no flush below threshold", 64'(beats - b0), 64'd0);
    send_frame(3, 32'h300);
    wait_irq("R2 threshold flush");
    check("R1 batch length", 64'(beats - b0), 64'd13);
    check("R1 header", 64'(host[0]), 64'd3);
    check("R1 first length", 64'(host[1]), 64'd3);
    check("R1 first data", 64'(host[2]), 64'h100);
    check("R1 second length", 64'(host[5]), 64'd3);
    check("R1 last data", 64'(host[12]), 64'h302);
    check("R4 burst limit", 64'(bad_burst), 64'd0);
    check("R5 irq after acks", 64'(early_irq), 64'd0);
    repeat (20) @(negedge clk);
    check("R5 irq held", 64'(irq), 64'd1);
    do_irq_ack();
    check("R5 irq cleared", 64'(irq), 64'd0);
    ready_mode = 0;
  endtask

  task automatic t_timeout();
    int b0, k;
    thresh = '1;
    timeout = TMR_W'(50);
    b0 = beats;
    send_frame(2, 32'h400);
    k = 0;
    while (!wr_valid && k < 200) begin
      @(negedge clk);
      k++;
    end
    n_chk++;
    if (k < 48 || k > 54) begin
      n_fail++;
      $display("FAIL R3 timeout delay: actual %0d expected 48..54", k);
    end
    wait_irq("R3 timeout flush");
    check("R3 batch length", 64'(beats - b0), 64'd4);
    check("R3 header", 64'(host[0]), 64'd1);
    check("R3 length word", 64'(host[1]), 64'd2);
    do_irq_ack();
    b0 = beats;
    repeat (200) @(negedge clk);
    check("R3 empty no flush", 64'(beats - b0), 64'd0);
    check("R3 empty no irq", 64'(irq), 64'd0);
  endtask

  task automatic t_full();
    int b0;
    thresh = '1;
    timeout = TMR_W'(4000);
    b0 = beats;
    send_frame(8, 32'h500);
    send_frame(8, 32'h600);
    send_frame(8, 32'h700);
    send_frame(8, 32'h800);
    send_frame(1, 32'h900);
    exp_drop += 2;
    @(negedge clk);
    check("R7 frames refused when full", 64'(drop_cnt), 64'(exp_drop));
    check("R7 no flush yet", 64'(beats - b0), 64'd0);
    timeout = TMR_W'(1);
    wait_irq("R7 flush");
    check("R7 batch length", 64'(beats - b0), 64'd28);
    check("R7 header", 64'(host[0]), 64'd3);
    check("R7 third length", 64'(host[19]), 64'd8);
    check("R7 last data", 64'(host[27]), 64'h707);
    timeout = TMR_W'(4000);
    do_irq_ack();
  endtask

  task automatic t_flush_drop();
    int b0;
    thresh = PTR_W'(4);
    timeout = TMR_W'(4000);
    ready_mode = 2;
    ack_hold = 1'b1;
    b0 = beats;
    send_frame(3, 32'hA00);
    repeat (3) @(negedge clk);
    send_frame(2, 32'hB00);
    exp_drop += 1;
    @(negedge clk);
    check("R6 drop during flush", 64'(drop_cnt), 64'(exp_drop));
    ready_mode = 0;
    repeat (30) @(negedge clk);
    check("R5 all beats out", 64'(beats - b0), 64'd5);
    check("R5 no irq before acks", 64'(irq), 64'd0);
    ack_hold = 1'b0;
    wait_irq("R5 irq after acks");
    check("R6 header", 64'(host[0]), 64'd1);
    check("R6 length word", 64'(host[1]), 64'd3);
    b0 = beats;
    send_frame(3, 32'hC00);
    repeat (30) @(negedge clk);
    check("R5 no flush while irq pending", 64'(beats - b0), 64'd0);
    do_irq_ack();
    wait_irq("R9 next flush");
    check("R9 next batch length", 64'(beats - b0), 64'd5);
    check("R9 header", 64'(host[0]), 64'd1);
    check("R9 data restarts", 64'(host[2]), 64'hC00);
    check("R5 no beat while irq", 64'(irq_beat), 64'd0);
    do_irq_ack();
  endtask

  task automatic t_oversize();
    int b0;
    thresh = '1;
    timeout = TMR_W'(100);
    b0 = beats;
    send_frame(9, 32'hD00);
    exp_drop += 1;
    @(negedge clk);
    check("R8 oversize dropped", 64'(drop_cnt), 64'(exp_drop));
    repeat (200) @(negedge clk);
    check("R8 buffer stayed empty", 64'(beats - b0), 64'd0);
    send_frame(8, 32'hE00);
    wait_irq("R8 max frame flush");
    check("R8 max frame length", 64'(host[1]), 64'd8);
    check("R8 max frame tail", 64'(host[9]), 64'hE07);
    do_irq_ack();
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_timeout();
    t_full();
    t_flush_drop();
    t_oversize();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule